// File: doc/BRIEF.md
# One-Pulse-Per-Second Phase Interval Meter

This block measures the time offset between two once-per-second pulses: a reference pulse from a timing receiver and a pulse from a device under test. A fast local clock is counted from the reference pulse's rising edge up to the device pulse's active edge. That count, minus a programmable setpoint, is presented once per second as a sample. The setpoint keeps normal operation away from the point where the two edges cross.

The device pulse may be inverted so that its falling edge becomes the active edge. The reference pulse is never altered, because only its rising edge is tightly controlled. Samples are summed over a programmable number of seconds (1 to 256). The wide sum is presented with a one-cycle strobe and the accumulator then restarts. Flags mark samples where the edges were too close together to trust, and report seconds where the device edge never arrived.

Top module: `pps_interval_meter`

## Requirements
- R1: After reset, `sample_out`, `sum_out`, `near_zero`, `sample_valid`, `missed` and `sum_valid` are all zero.
- R2: For a device edge that arrives D clock cycles after the reference rising edge, the raw count is D. `sample_valid` pulses for one cycle, 3 clock edges after the device input changes.
- R3: Only the reference rising edge opens the gate; a reference falling edge during the gate has no effect. Device edges while the gate is closed are ignored: they produce no sample and leave `sample_out` unchanged.
- R4: `sample_out` equals the raw count minus `offset`, modulo 2^CNT_W (CNT_W = 24 by default).
- R5: `near_zero` is 1 with a sample exactly when the raw count is below CLK_HZ/1,000,000 (50 for a 50 MHz clock), and 0 otherwise.
- R6: With the invert control active, the device pulse's falling edge (1 to 0) is the active edge. The reference pulse is never inverted.
- R7: A change of `inv_en` while the gate is open does not affect that window; it takes effect only once the gate has closed.
- R8: A reference rising edge while the gate is still open gives a one-cycle `missed` strobe with no `sample_valid`. The missed second is not added to the sum, and the gate restarts counting from that edge.
- R9: Each sample is zero-extended and added to a running sum. When `nsamp` samples have been summed, `sum_valid` pulses one cycle after that `sample_valid`, `sum_out` carries the total, and the sum restarts from zero. An `nsamp` of 0 is treated as 1.
- R10: `sample_out` and `near_zero` hold between `sample_valid` strobes, and `sum_out` holds between `sum_valid` strobes.
- R11: Reference and device edges detected in the same cycle give a raw count of 0, with `near_zero` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pps | input | 1 | Reference once-per-second pulse, asynchronous |
| dut_pps | input | 1 | Device-under-test once-per-second pulse, asynchronous |
| inv_en | input | 1 | 1 makes the device pulse's falling edge active |
| nsamp | input | NS_W (9) | Number of samples per sum, 1 to 256 (0 acts as 1) |
| offset | input | CNT_W (24) | Setpoint subtracted from each raw count |
| sample_out | output | CNT_W (24) | Last sample, raw count minus setpoint |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| near_zero | output | 1 | The last sample's edges were closer than 1 us |
| missed | output | 1 | One-cycle strobe: gate restarted with no device edge |
| sum_out | output | ACC_W (32) | Last completed sum |
| sum_valid | output | 1 | One-cycle strobe for a new sum |

## Verification
Each input edge passes two synchronizer flops and an edge-history flop before the gate logic acts on it. The sample and `missed` strobes are therefore due exactly 3 clock edges after the input is driven, and the sum strobe one edge after that. The bench drives inputs on falling clock edges and counts falling edges from the device edge until `sample_valid` appears; the count must be 3. The sum is read on the falling edge after the sample, and "no effect" cases are read on the ports over a window of at least that length.

// File: rtl/pim_pkg.sv
package pim_pkg;

    localparam int unsigned HZ_PER_MHZ = 1_000_000;

    // Gate state of the interval counter
    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;

    // Per-sample status carried alongside the sample value
    typedef struct packed {
        logic valid;
        logic missed;
        logic near;
    } smp_flags_t;

    // Count that corresponds to one microsecond of the count clock
    function automatic int unsigned near_limit(input int unsigned clk_hz);
        return clk_hz / HZ_PER_MHZ;
    endfunction

endpackage

// File: rtl/pim_edge_sync.sv
module pim_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic pol,
    output logic rise
);
    // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    // Polarity is applied to both taps, so a polarity change alone never
    // looks like an edge
    assign rise = (chain[STAGES-1] ^ pol) & ~(chain[STAGES] ^ pol);
endmodule

// File: rtl/pim_gate_ctr.sv
module pim_gate_ctr
    import pim_pkg::*;
#(
    parameter int          CNT_W    = 24,
    parameter int unsigned NEAR_LIM = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_rise,
    input  logic             dut_rise,
    input  logic [CNT_W-1:0] offset,
    output logic             gate_open,
    output smp_flags_t       flags,
    output logic [CNT_W-1:0] smp_value
);
    localparam logic [CNT_W-1:0] NEAR_V = CNT_W'(NEAR_LIM);
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    gate_state_e      st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] raw_sel;
    logic             emit;

    assign cnt_inc   = cnt + ONE_V;
    assign gate_open = (st == GATE_OPEN);
    // Count for a closing edge: both edges together give zero
    assign raw_sel   = gate_open ? cnt_inc : '0;
    assign emit      = dut_rise & (gate_open | ref_rise);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= GATE_IDLE;
            cnt       <= '0;
            smp_value <= '0;
            flags     <= '0;
        end else begin
            flags.valid  <= 1'b0;
            flags.missed <= 1'b0;
            if (emit) begin
                flags.valid <= 1'b1;
                flags.near  <= (raw_sel < NEAR_V);
                smp_value   <= raw_sel - offset;
            end
            unique case (st)
                GATE_IDLE: begin
                    if (ref_rise) begin
                        cnt <= '0;
                        if (!dut_rise) st <= GATE_OPEN;
                    end
                end
                GATE_OPEN: begin
                    if (dut_rise) begin
                        cnt <= '0;
                        if (!ref_rise) st <= GATE_IDLE;
                    end else if (ref_rise) begin
                        flags.missed <= 1'b1;
                        cnt          <= '0;
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                default: st <= GATE_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pim_accum.sv
module pim_accum #(
    parameter int CNT_W = 24,
    parameter int ACC_W = 32,
    parameter int NS_W  = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [CNT_W-1:0] smp_value,
    input  logic [NS_W-1:0]  nsamp,
    output logic [ACC_W-1:0] sum_out,
    output logic             sum_valid
);
    logic [NS_W-1:0]  n;
    logic [NS_W:0]    n_next;
    logic [NS_W:0]    tgt;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;

    assign n_next   = {1'b0, n} + (NS_W+1)'(1);
    assign tgt      = (nsamp == '0) ? (NS_W+1)'(1) : {1'b0, nsamp};
    assign acc_next = acc + ACC_W'(smp_value);

    always_ff @(posedge clk) begin
        if (rst) begin
            n         <= '0;
            acc       <= '0;
            sum_out   <= '0;
            sum_valid <= 1'b0;
        end else begin
            sum_valid <= 1'b0;
            if (smp_valid) begin
                if (n_next >= tgt) begin
                    sum_out   <= acc_next;
                    sum_valid <= 1'b1;
                    acc       <= '0;
                    n         <= '0;
                end else begin
                    acc <= acc_next;
                    n   <= n_next[NS_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/pps_interval_meter.sv
module pps_interval_meter
    import pim_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 16_000_000,
    parameter int          CNT_W       = 24,
    parameter int          ACC_W       = 32,
    parameter int          MAX_SAMPLES = 256,
    parameter int          SYNC_STAGES = 2,
    localparam int         NS_W        = $clog2(MAX_SAMPLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_pps,
    input  logic             dut_pps,
    input  logic             inv_en,
    input  logic [NS_W-1:0]  nsamp,
    input  logic [CNT_W-1:0] offset,
    output logic [CNT_W-1:0] sample_out,
    output logic             sample_valid,
    output logic             near_zero,
    output logic             missed,
    output logic [ACC_W-1:0] sum_out,
    output logic             sum_valid
);
    localparam int unsigned NEAR_LIM = near_limit(CLK_HZ);
    localparam int          N_CH     = 2;

    logic             inv_act;
    logic             gate_open;
    logic             ref_rise;
    logic             dut_rise;
    logic [N_CH-1:0]  raw_in;
    logic [N_CH-1:0]  pol_in;
    logic [N_CH-1:0]  rise_v;
    smp_flags_t       flags;

    // Channel 0 is the reference (never inverted), channel 1 the device
    assign raw_in = {dut_pps, ref_pps};
    assign pol_in = {inv_act, 1'b0};

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        pim_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .pol  (pol_in[g]),
            .rise (rise_v[g])
        );
    end

    assign ref_rise = rise_v[0];
    assign dut_rise = rise_v[1];

    // Polarity is only picked up while no window is running
    always_ff @(posedge clk) begin
        if (rst)             inv_act <= 1'b0;
        else if (!gate_open) inv_act <= inv_en;
    end

    pim_gate_ctr #(.CNT_W(CNT_W), .NEAR_LIM(NEAR_LIM)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .ref_rise  (ref_rise),
        .dut_rise  (dut_rise),
        .offset    (offset),
        .gate_open (gate_open),
        .flags     (flags),
        .smp_value (sample_out)
    );

    assign sample_valid = flags.valid;
    assign near_zero    = flags.near;
    assign missed       = flags.missed;

    pim_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W), .NS_W(NS_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (flags.valid),
        .smp_value (sample_out),
        .nsamp     (nsamp),
        .sum_out   (sum_out),
        .sum_valid (sum_valid)
    );
endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
    parameter int CNT_W = 24,
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_rise,
    input logic             gate_open,
    input logic             inv_act,
    input logic             sample_valid,
    input logic [CNT_W-1:0] sample_out,
    input logic             near_zero,
    input logic             missed,
    input logic             sum_valid,
    input logic [ACC_W-1:0] sum_out
);
    p_gate_on_ref_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_open) |-> $past(ref_rise));

    p_inv_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(inv_act) |-> !$past(gate_open));

    p_missed_excl_r8: assert property (@(posedge clk) disable iff (rst)
        missed |-> !sample_valid);

    p_sum_after_sample_r9: assert property (@(posedge clk) disable iff (rst)
        sum_valid |-> $past(sample_valid));

    p_sample_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> ($stable(sample_out) && $stable(near_zero)));

    p_sum_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !sum_valid |-> $stable(sum_out));
endmodule

bind pps_interval_meter pim_checker #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ref_rise     (ref_rise),
    .gate_open    (gate_open),
    .inv_act      (inv_act),
    .sample_valid (sample_valid),
    .sample_out   (sample_out),
    .near_zero    (near_zero),
    .missed       (missed),
    .sum_valid    (sum_valid),
    .sum_out      (sum_out)
);

// File: tb/tb_pps_interval_meter.sv
module tb_pps_interval_meter;
    localparam int unsigned CLK_HZ = 50_000_000;
    localparam int CNT_W = 24;
    localparam int ACC_W = 32;
    localparam int NS_W  = 9;
    localparam int NEAR  = 50;            // 1 us at 50 MHz
    localparam int LAT   = 3;             // edges from input to sample strobe

    // Vector table: device delay, setpoint, inversion
    localparam int NV = 7;
    localparam int V_D[NV]   = '{120, 49, 50, 200, 10, 90, 30};
    localparam int V_OFF[NV] = '{0,   0,  0,  80,  25, 0,  5};
    localparam bit V_INV[NV] = '{0,   0,  0,  0,   0,  1,  1};

    logic             clk = 0;
    logic             rst = 1;
    logic             ref_pps = 0;
    logic             dut_pps = 0;
    logic             inv_en = 0;
    logic [NS_W-1:0]  nsamp = 1;
    logic [CNT_W-1:0] offset = '0;
    logic [CNT_W-1:0] sample_out;
    logic             sample_valid;
    logic             near_zero;
    logic             missed;
    logic [ACC_W-1:0] sum_out;
    logic             sum_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pps_interval_meter #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W), .ACC_W(ACC_W)) dut (
        .clk(clk), .rst(rst), .ref_pps(ref_pps), .dut_pps(dut_pps),
        .inv_en(inv_en), .nsamp(nsamp), .offset(offset),
        .sample_out(sample_out), .sample_valid(sample_valid),
        .near_zero(near_zero), .missed(missed),
        .sum_out(sum_out), .sum_valid(sum_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Counts falling edges until sample_valid is seen (bounded)
    task automatic wait_sample(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!sample_valid && k < 40);
    endtask

    task automatic measure(input int d, input bit inv, input string tag,
                           input logic [31:0] exp_v, input bit exp_nz,
                           input bit exp_sv, input logic [31:0] exp_sm);
        int k;
        inv_en  = inv;
        dut_pps = inv;
        repeat (6) @(negedge clk);
        ref_pps = 1;
        if (d > 0) repeat (d) @(negedge clk);
        dut_pps = !inv;
        wait_sample(k);
        chk({tag, " R2 latency"}, k, LAT);
        chk({tag, " R2/R4 sample"}, sample_out, exp_v);
        chk({tag, " R5 near_zero"}, near_zero, exp_nz);
        @(negedge clk);
        chk({tag, " R9 sum_valid"}, sum_valid, exp_sv);
        if (exp_sv) chk({tag, " R9 sum_out"}, sum_out, exp_sm);
        ref_pps = 0;
        dut_pps = inv;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int k;
        logic [CNT_W-1:0] held;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 sample_out", sample_out, 0);
        chk("R1 sum_out", sum_out, 0);
        chk("R1 strobes", {sample_valid, near_zero, missed, sum_valid}, 0);

        // Vector table walk, one sample per sum (R4 R5 R6 R9)
        for (int i = 0; i < NV; i++) begin
            logic [CNT_W-1:0] ev;
            offset = CNT_W'(V_OFF[i]);
            ev = CNT_W'(V_D[i]) - CNT_W'(V_OFF[i]);
            measure(V_D[i], V_INV[i], V_INV[i] ? "R6 vec" : "R4 vec",
                    32'(ev), (V_D[i] < NEAR), 1'b1, 32'(ev));
        end
        offset = '0;

        // R11 coincident edges
        measure(0, 0, "R11 coincident", 0, 1'b1, 1'b1, 0);

        // R3 device pulse with gate closed is ignored
        held = sample_out;
        repeat (4) @(negedge clk);
        dut_pps = 1;
        k = 0;
        repeat (12) begin
            @(negedge clk);
            if (sample_valid || missed) k++;
        end
        chk("R3 idle device edge strobes", k, 0);
        chk("R3 idle device edge sample_out", sample_out, held);
        dut_pps = 0;
        repeat (6) @(negedge clk);

        // R3 reference trailing edge mid-gate has no effect
        ref_pps = 1;
        repeat (5) @(negedge clk);
        ref_pps = 0;
        repeat (25) @(negedge clk);
        dut_pps = 1;
        wait_sample(k);
        chk("R3 trailing edge sample", sample_out, 30);
        dut_pps = 0;
        repeat (8) @(negedge clk);

        // R7 inversion change inside an open window is deferred
        ref_pps = 1;
        repeat (5) @(negedge clk);
        inv_en = 1;
        repeat (35) @(negedge clk);
        dut_pps = 1;
        wait_sample(k);
        chk("R7 latency", k, LAT);
        chk("R7 deferred inversion sample", sample_out, 40);
        inv_en  = 0;
        ref_pps = 0;
        repeat (8) @(negedge clk);
        dut_pps = 0;
        repeat (8) @(negedge clk);

        // R8 missed device pulse, then two samples summed (nsamp = 2)
        nsamp = 2;
        ref_pps = 1;
        repeat (20) @(negedge clk);
        ref_pps = 0;
        repeat (20) @(negedge clk);
        ref_pps = 1;
        repeat (LAT) @(negedge clk);
        chk("R8 missed strobe", missed, 1);
        chk("R8 no sample on miss", sample_valid, 0);
        repeat (15 - LAT) @(negedge clk);
        dut_pps = 1;
        wait_sample(k);
        chk("R8 restart count", sample_out, 15);
        @(negedge clk);
        chk("R9 no sum after first of two", sum_valid, 0);
        ref_pps = 0;
        dut_pps = 0;
        repeat (8) @(negedge clk);
        measure(60, 0, "R9 second of two", 60, 1'b0, 1'b1, 75);

        // R9 nsamp of zero acts as one
        nsamp = 0;
        measure(70, 0, "R9 nsamp zero", 70, 1'b0, 1'b1, 70);

        // R10 outputs hold with no new strobes
        held = sample_out;
        repeat (10) @(negedge clk);
        chk("R10 sample hold", sample_out, held);
        chk("R10 sum hold", sum_out, 70);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule